// File: doc/BRIEF.md
# Comma-aligning 10-bit deserializer

This block turns a retimed serial bit stream into 10-bit code groups. It runs on one bit-rate clock. A bit-valid input tells it whether serial data is present. A 10-bit sliding window is shifted on every bit clock and searched for the positive-disparity comma. When a comma lands off the current word boundary, the block moves the boundary onto it.

Two complementary byte clocks run at half the word rate, so each phase lasts one word. The block holds a byte-clock phase longer rather than cutting it short. This keeps every high and low phase at least one word long. It also places the rising edge of the second clock on the comma word of each aligned 4-word ordered set.

A lock input freezes the boundary where it is, while the byte clocks keep their nominal rhythm. Downstream logic can capture the word on either byte clock, because the word changes only when the byte clocks change.

Top module: `comma_deser`

## Requirements
- R1: The first bit received in a code group is placed in bit 0 of `word_o`, and the last bit in bit 9. The word is presented after the edge that samples its tenth bit, together with a byte-clock transition.
- R2: A comma is a window whose seven oldest bits, in receive order, are 0,0,1,1,1,1,1; the last three bits are ignored. When an aligned comma word is output, `comma_o` is 1 with that word. At all other times `comma_o` is 0.
- R3: `bclk0_o` is always the complement of `bclk1_o`. With no realignment, each phase lasts exactly 10 bit clocks. `word_o` changes only in the cycle in which the byte clocks change.
- R4: No byte-clock phase is ever shorter than 10 bit clocks. A comma that ends off the boundary makes the word ending 10 bit clocks later the new boundary. Any transition that would have come earlier is held back, and the word at the held-back boundary is not output.
- R5: After realignment, a comma sent as the first word of each 4-word ordered set is output as `bclk1_o` rises (0 to 1), with `comma_o` = 1. This holds from the second comma onward.
- R6: While `ref_lock_i` = 1 or `bit_vld_i` = 0, a comma causes no realignment. In that state the byte clocks still toggle every 10 bit clocks on the existing schedule.
- R7: After reset, `bclk1_o` = 1, `bclk0_o` = 0, `word_o` = 0, `word_vld_o` = 0 and `comma_o` = 0. The first transition (`bclk1_o` falling) comes after the tenth bit clock.
- R8: `word_vld_o` stays 0 until a comma has been accepted. It is 1 on every word output after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | Serial data present on `bit_i` |
| bit_i | input | 1 | Retimed serial bit |
| ref_lock_i | input | 1 | Lock to reference: disables realignment |
| word_o | output | 10 | Recovered code group, first received bit in bit 0 |
| word_vld_o | output | 1 | Word follows an accepted comma |
| comma_o | output | 1 | Output word is an aligned comma |
| bclk0_o | output | 1 | Byte clock, rises on odd words |
| bclk1_o | output | 1 | Byte clock, rises on comma-aligned words |

## Verification
A wrong phase counter or a lost hold shows within one word. A byte-clock phase comes out shorter than 10 bit clocks, or the next word is framed off by a few bits. An error in the boundary or the parity appears when the following comma arrives. That comma is either absent from `word_o`, or it arrives on a falling `bclk1_o` with `comma_o` low, at most one ordered set (40 bit clocks) later. A realignment that ignores the lock or the data-valid input shifts the next byte-clock transition away from its 10-cycle slot at once.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
    // Comma prefix in receive order: bit 0 is the first bit received.
    localparam int unsigned    COMMA_LEN  = 7;
    localparam logic [6:0]     COMMA_BITS = 7'b1111100;
endpackage

// File: rtl/comma_deser_shift.sv
module comma_deser_shift #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    output logic [WORD_W-1:0] win_o
);
    logic [WORD_W-1:0] win_d, win_q;

    // Newest bit enters at the top, so the oldest bit sits in bit 0.
    always_comb begin
        win_d = {bit_i, win_q[WORD_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_o = win_d;
endmodule

// File: rtl/comma_deser_match.sv
module comma_deser_match #(
    parameter int unsigned          PAT_W = 7,
    parameter logic [PAT_W-1:0]     PAT   = '0
) (
    input  logic [PAT_W-1:0] win_i,
    output logic             hit_o
);
    logic [PAT_W-1:0] eq;

    for (genvar g = 0; g < PAT_W; g++) begin : g_bit
        assign eq[g] = (win_i[g] == PAT[g]);
    end

    assign hit_o = &eq;
endmodule

// File: rtl/comma_deser_clkgen.sv
module comma_deser_clkgen #(
    parameter int unsigned WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign_i,
    output logic load_o,
    output logic at_rise_o,
    output logic bclk0_o,
    output logic bclk1_o
);
    localparam int unsigned PER = 2 * WORD_W;
    localparam int unsigned CW  = $clog2(PER);
    localparam logic [CW-1:0] FALL_AT = CW'(WORD_W - 1);
    localparam logic [CW-1:0] RISE_AT = CW'(PER - 1);

    typedef struct packed {
        logic [CW-1:0] pc;
        logic          b0;
        logic          b1;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    fall_now, rise_now;

    always_comb begin
        st_d     = st_q;
        fall_now = 1'b0;
        rise_now = 1'b0;
        if (realign_i) begin
            // Restart the period here; hold the clock levels (stretch).
            st_d.pc = '0;
        end else begin
            st_d.pc = (st_q.pc == RISE_AT) ? '0 : st_q.pc + 1'b1;
            if (st_q.pc == FALL_AT && st_q.b1) begin
                fall_now = 1'b1;
                st_d.b1  = 1'b0;
                st_d.b0  = 1'b1;
            end
            if (st_q.pc == RISE_AT && !st_q.b1) begin
                rise_now = 1'b1;
                st_d.b1  = 1'b1;
                st_d.b0  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pc: '0, b0: 1'b0, b1: 1'b1};
        else        st_q <= st_d;
    end

    assign load_o    = fall_now | rise_now;
    assign at_rise_o = (st_q.pc == RISE_AT);
    assign bclk0_o   = st_q.b0;
    assign bclk1_o   = st_q.b1;
endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import comma_deser_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              ref_lock_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              comma_o,
    output logic              bclk0_o,
    output logic              bclk1_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              comma;
        logic              sync;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [WORD_W-1:0] win;
    logic              hit, det, realign, load, at_rise;

    comma_deser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (bit_i),
        .win_o (win)
    );

    comma_deser_match #(.PAT_W(COMMA_LEN), .PAT(COMMA_BITS)) u_match (
        .win_i (win[COMMA_LEN-1:0]),
        .hit_o (hit)
    );

    // A comma counts only with live data and realignment enabled.
    assign det     = hit & bit_vld_i & ~ref_lock_i;
    assign realign = det & ~at_rise;

    comma_deser_clkgen #(.WORD_W(WORD_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign_i (realign),
        .load_o    (load),
        .at_rise_o (at_rise),
        .bclk0_o   (bclk0_o),
        .bclk1_o   (bclk1_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sync = st_q.sync | det;
        if (load) begin
            st_d.word  = win;
            st_d.vld   = st_d.sync;
            st_d.comma = det;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o     = st_q.word;
    assign word_vld_o = st_q.vld;
    assign comma_o    = st_q.comma;
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk
    import comma_deser_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              comma_o,
    input logic              bclk1_o
);
    localparam int unsigned RW = $clog2(4 * WORD_W) + 1;

    logic          prev_q;
    logic [RW-1:0] run_q;

    // Cycles for which bclk1 has held its level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= '0;
        end else begin
            prev_q <= bclk1_o;
            if (bclk1_o != prev_q)  run_q <= '0;
            else if (&run_q == 1'b0) run_q <= run_q + 1'b1;
        end
    end

    assert_word_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> !$stable(bclk1_o));

    assert_comma_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> (word_o[COMMA_LEN-1:0] == COMMA_BITS));

    assert_comma_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> bclk1_o);

    assert_comma_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> word_vld_o);

    assert_no_short_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk1_o != prev_q) |-> (run_q >= RW'(WORD_W - 1)));
endmodule

bind comma_deser comma_deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .comma_o    (comma_o),
    .bclk1_o    (bclk1_o)
);

// File: tb/comma_deser_bench.sv
module comma_deser_bench;
    localparam int          W  = 10;
    localparam logic [9:0]  KC = 10'h17C;  // comma, bit 0 sent first
    localparam logic [9:0]  DA = 10'h2AA;
    localparam logic [9:0]  DB = 10'h155;
    localparam logic [9:0]  DC = 10'h333;
    // {expected bclk1, expected comma, word sent}; walked once the stream is aligned
    localparam logic [11:0] TBL [8] = '{
        {2'b00, DC}, {2'b11, KC},   // second comma: on the rise (R5)
        {2'b00, DA}, {2'b10, DB},
        {2'b00, DC}, {2'b11, KC},
        {2'b00, DA}, {2'b10, DB}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_vld = 1'b0;
    logic         bit_in = 1'b0;
    logic         ref_lock = 1'b0;
    logic [W-1:0] word;
    logic         word_vld, comma, bclk0, bclk1;
    int           checks = 0;
    int           errors = 0;
    int           phase_err = 0;
    int           wchg_err = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    comma_deser #(.WORD_W(W)) u_comma_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (bit_vld),
        .bit_i      (bit_in),
        .ref_lock_i (ref_lock),
        .word_o     (word),
        .word_vld_o (word_vld),
        .comma_o    (comma),
        .bclk0_o    (bclk0),
        .bclk1_o    (bclk1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [9:0] w, input int lo, input int hi, input logic v);
        for (int i = lo; i <= hi; i++) begin
            bit_in  = w[i];
            bit_vld = v;
            @(negedge clk);
        end
    endtask

    // Phase length and word-stability monitor (R3, R4)
    logic         mon_b1;
    logic [W-1:0] mon_word;
    int           mon_run = 0;
    bit           mon_started = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bclk1 != mon_b1) begin
                if (mon_started && mon_run < W) phase_err++;
                mon_started = 1'b1;
                mon_run = 1;
            end else begin
                mon_run++;
                if (word != mon_word) wchg_err++;
            end
        end
        mon_b1   = bclk1;
        mon_word = word;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        chk(bclk1 == 1'b1 && bclk0 == 1'b0, "R7 clocks", {bclk1, bclk0}, 2'b10);
        chk(word == '0 && word_vld == 1'b0 && comma == 1'b0, "R7 outputs", {word, word_vld, comma}, 0);

        // Unaligned start: 3 filler bits, then the comma
        send_bits(10'h000, 0, 2, 1'b1);
        send_bits(KC, 0, 6, 1'b1);
        chk(bclk1 == 1'b0 && bclk0 == 1'b1, "R7 first fall after 10 bits", {bclk1, bclk0}, 2'b01);
        chk(word_vld == 1'b0, "R8 invalid before comma", word_vld, 0);
        send_bits(KC, 7, 9, 1'b1);
        chk(bclk1 == 1'b0 && word_vld == 1'b0, "R4 realign holds low", {bclk1, word_vld}, 0);
        send_bits(DA, 0, 9, 1'b1);
        chk(bclk1 == 1'b0 && word_vld == 1'b0, "R4 held-back boundary skipped", {bclk1, word_vld}, 0);
        send_bits(DB, 0, 9, 1'b1);
        chk(bclk1 == 1'b1 && word == DB, "R1 first framed word", {bclk1, word}, {1'b1, DB});
        chk(word_vld == 1'b1 && comma == 1'b0, "R8 valid after comma", {word_vld, comma}, 2'b10);

        // Aligned stream walked from the table
        for (int i = 0; i < 8; i++) begin
            send_bits(TBL[i][9:0], 0, 9, 1'b1);
            chk(word == TBL[i][9:0], "R1 word", word, TBL[i][9:0]);
            chk(comma == TBL[i][10], "R2 R5 comma flag", comma, TBL[i][10]);
            chk(bclk1 == TBL[i][11] && bclk0 == ~TBL[i][11], "R3 clock levels", {bclk1, bclk0}, {TBL[i][11], ~TBL[i][11]});
        end

        // Slip while bclk1 is high
        send_bits(DA, 0, 9, 1'b1);
        chk(bclk1 == 1'b0 && word == DA, "R3 nominal fall", {bclk1, word}, {1'b0, DA});
        send_bits(10'h015, 0, 5, 1'b1);
        send_bits(KC, 0, 3, 1'b1);
        chk(bclk1 == 1'b1 && word == 10'h315, "R1 partial word at rise", {bclk1, word}, {1'b1, 10'h315});
        send_bits(KC, 4, 9, 1'b1);
        chk(bclk1 == 1'b1, "R4 high phase stretched", bclk1, 1);
        send_bits(DB, 0, 9, 1'b1);
        chk(bclk1 == 1'b0 && word == DB, "R4 new boundary", {bclk1, word}, {1'b0, DB});
        send_bits(DC, 0, 9, 1'b1);
        chk(bclk1 == 1'b1 && word == DC, "R4 rise after realign", {bclk1, word}, {1'b1, DC});
        send_bits(DA, 0, 9, 1'b1);
        send_bits(KC, 0, 9, 1'b1);
        chk(bclk1 == 1'b1 && comma == 1'b1 && word == KC, "R5 second comma on rise", {bclk1, comma, word}, {2'b11, KC});

        // Lock to reference: misaligned comma ignored
        ref_lock = 1'b1;
        send_bits(10'h000, 0, 2, 1'b1);
        send_bits(KC, 0, 6, 1'b1);
        chk(bclk1 == 1'b0 && word == 10'h3E0 && comma == 1'b0, "R6 lock keeps fall slot", {bclk1, comma, word}, {2'b00, 10'h3E0});
        send_bits(KC, 7, 9, 1'b1);
        send_bits(10'h000, 0, 6, 1'b1);
        chk(bclk1 == 1'b1 && word == 10'h002, "R6 lock keeps rise slot", {bclk1, word}, {1'b1, 10'h002});
        ref_lock = 1'b0;

        // No data present: comma pattern on the line ignored
        send_bits(10'h000, 0, 2, 1'b0);
        send_bits(KC, 0, 6, 1'b0);
        chk(bclk1 == 1'b0 && comma == 1'b0, "R6 no data fall slot", {bclk1, comma}, 0);
        send_bits(KC, 7, 9, 1'b0);
        send_bits(10'h000, 0, 6, 1'b0);
        chk(bclk1 == 1'b1, "R6 no data rise slot", bclk1, 1);
        send_bits(DA, 0, 9, 1'b1);
        chk(bclk1 == 1'b0 && word == DA && word_vld == 1'b1, "R6 framing kept", {bclk1, word_vld, word}, {2'b01, DA});

        chk(phase_err == 0, "R4 minimum phase length", phase_err, 0);
        chk(wchg_err == 0, "R3 word changes only on clock edge", wchg_err, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule